// File: doc/BRIEF.md
# Disc Brake Completion Detector

This block brakes the spindle of an optical disc and decides when the disc has slowed enough. A host microcontroller sends 8-bit command codes that set the brake options and start or stop a brake. While a brake runs, the block counts transitions on the digitized channel-bit (EFM) stream in each frame, using a frame strobe to mark frame boundaries. A fast disc produces many transitions per frame and a slow one produces few. When a complete frame holds fewer transitions than the selected threshold, the brake is judged finished.

Outside a brake, the motor-drive and tracking-off outputs pass the normal servo values through unchanged. During a brake the block takes over both outputs. It raises a brake-complete flag so the host can then send a stop command. A continuous option keeps the braking drive on after completion. A hold option keeps tracking forced off while braking is in effect.

Top module: `disc_brake_ctrl`

## Requirements
- R1: After reset, braking is disabled, the threshold is 4, continuous and hold modes are off, no brake is running, `brake_done` is low, and both outputs follow their servo inputs.
- R2: Code 0xC5 enables braking and 0xC4 disables it. A brake code 0x06 received while braking is disabled is ignored, so the outputs keep following the servo inputs and `brake_done` stays low.
- R3: Code 0x06 received while braking is enabled starts a brake. From the next cycle `motor_drv_out` is 1 and `brake_done` is 0. This also clears an earlier completion.
- R4: Transitions are counted on both edges of a two-flop synchronized copy of `efm_in`. The count covers the span between two frame strobes. The first strobe after a brake starts only opens the first full frame and makes no decision.
- R5: At a decision strobe, if the frame count is below the threshold, then from the next cycle `brake_done` is 1 and `motor_drv_out` is 0, unless continuous mode is on. A count equal to the threshold does not end the brake.
- R6: The threshold is 4 by default. Code 0xA3 raises it to 8, and only reset brings it back to 4.
- R7: The per-frame count saturates at 2^CNT_W-1 (15 by default) and does not wrap. With the default width, a frame of 18 transitions does not end a brake.
- R8: Code 0xCB turns on continuous mode, in which `motor_drv_out` stays 1 after `brake_done` rises. Code 0xCA turns it off.
- R9: Code 0xCD turns on hold mode, in which `track_off_out` is 0 while a brake runs or a continuous-mode completion holds the drive. Code 0xCC turns it off, and then `track_off_out` follows `servo_trkoff_in`.
- R10: The stop code (0x02 by default) ends any brake. From the next cycle `brake_done` is 0 and both outputs follow their servo inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command code is valid this cycle |
| cmd_code | input | 8 | Host command code |
| efm_in | input | 1 | Asynchronous digitized channel-bit signal |
| frame_strobe | input | 1 | One-cycle pulse at each frame boundary |
| servo_motor_in | input | 1 | Normal spindle-drive value from the servo |
| servo_trkoff_in | input | 1 | Normal tracking-off value from the servo |
| motor_drv_out | output | 1 | Spindle drive; 1 is the braking level |
| brake_done | output | 1 | Brake-complete flag |
| track_off_out | output | 1 | Tracking-off output |

## Verification
The hardest situations to reach are the count boundaries: a frame holding exactly the threshold number of transitions, and a frame whose count would wrap to a small value if the counter were not saturating. The bench builds each frame by toggling `efm_in` a known number of times, with each level held two cycles so that every toggle survives the synchronizer. It then waits for the last toggle to reach the counter before pulsing the strobe. Every brake opens with a throwaway arming frame, so the decision frames are complete frames.

// File: rtl/brake_pkg.sv
package brake_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BRAKE = 2'd1,
    ST_DONE  = 2'd2
  } brake_st_e;

  localparam logic [7:0] CMD_BRK_ON   = 8'hC5;
  localparam logic [7:0] CMD_BRK_OFF  = 8'hC4;
  localparam logic [7:0] CMD_THR_HI   = 8'hA3;
  localparam logic [7:0] CMD_CONT_ON  = 8'hCB;
  localparam logic [7:0] CMD_CONT_OFF = 8'hCA;
  localparam logic [7:0] CMD_HOLD_ON  = 8'hCD;
  localparam logic [7:0] CMD_HOLD_OFF = 8'hCC;
  localparam logic [7:0] CMD_BRAKE    = 8'h06;
endpackage

// File: rtl/brake_mode_regs.sv
module brake_mode_regs
  import brake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic       brk_en,
  output logic       thr_hi,
  output logic       cont_mode,
  output logic       hold_mode
);
  logic brk_en_d, thr_hi_d, cont_d, hold_d;

  always_comb begin
    brk_en_d = brk_en;
    thr_hi_d = thr_hi;
    cont_d   = cont_mode;
    hold_d   = hold_mode;
    if (cmd_valid) begin
      case (cmd_code)
        CMD_BRK_ON:   brk_en_d = 1'b1;
        CMD_BRK_OFF:  brk_en_d = 1'b0;
        CMD_THR_HI:   thr_hi_d = 1'b1;
        CMD_CONT_ON:  cont_d   = 1'b1;
        CMD_CONT_OFF: cont_d   = 1'b0;
        CMD_HOLD_ON:  hold_d   = 1'b1;
        CMD_HOLD_OFF: hold_d   = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_en    <= 1'b0;
      thr_hi    <= 1'b0;
      cont_mode <= 1'b0;
      hold_mode <= 1'b0;
    end else begin
      brk_en    <= brk_en_d;
      thr_hi    <= thr_hi_d;
      cont_mode <= cont_d;
      hold_mode <= hold_d;
    end
  end

  // R6: once raised, the threshold select only returns low through reset
  a_r6_thr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hi |=> thr_hi);
endmodule

// File: rtl/efm_frame_counter.sv
module efm_frame_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             efm_in,
  input  logic             frame_strobe,
  output logic [CNT_W-1:0] frame_total
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             sync1, sync2, sync3;
  logic             edge_seen;
  logic [CNT_W-1:0] cnt, cnt_d, cnt_inc;

  assign edge_seen   = sync2 ^ sync3;
  assign cnt_inc     = (edge_seen && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
  assign frame_total = cnt_inc;

  always_comb begin
    cnt_d = cnt_inc;
    if (frame_strobe) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
      cnt   <= '0;
    end else begin
      sync1 <= efm_in;
      sync2 <= sync1;
      sync3 <= sync2;
      cnt   <= cnt_d;
    end
  end

  // R7: a full counter stays full until the next strobe
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !frame_strobe) |=> cnt == CNT_MAX);
  // R4: each strobe starts the next frame from zero
  a_r4_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> cnt <= CNT_W'(1));
endmodule

// File: rtl/brake_seq.sv
module brake_seq
  import brake_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             frame_strobe,
  input  logic [CNT_W-1:0] frame_total,
  input  logic [CNT_W-1:0] threshold,
  output brake_st_e        state
);
  brake_st_e state_d;
  logic      armed, armed_d;

  always_comb begin
    state_d = state;
    armed_d = armed;
    if (stop) begin
      state_d = ST_IDLE;
      armed_d = 1'b0;
    end else if (start) begin
      state_d = ST_BRAKE;
      armed_d = 1'b0;
    end else if (state == ST_BRAKE && frame_strobe) begin
      armed_d = 1'b1;
      if (armed && frame_total < threshold) state_d = ST_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      armed <= 1'b0;
    end else begin
      state <= state_d;
      armed <= armed_d;
    end
  end

  // R4: no decision on the strobe that only opens the first frame
  a_r4_arm_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRAKE && !armed && !stop && !start) |=> state == ST_BRAKE);
  // R10: stop always returns to idle
  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> state == ST_IDLE);
endmodule

// File: rtl/disc_brake_ctrl.sv
module disc_brake_ctrl
  import brake_pkg::*;
#(
  parameter int         CNT_W    = 4,
  parameter int         THR_LO   = 4,
  parameter int         THR_HI   = 8,
  parameter logic [7:0] CMD_STOP = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       efm_in,
  input  logic       frame_strobe,
  input  logic       servo_motor_in,
  input  logic       servo_trkoff_in,
  output logic       motor_drv_out,
  output logic       brake_done,
  output logic       track_off_out
);
  localparam logic [CNT_W-1:0] THR_LO_V = CNT_W'(THR_LO);
  localparam logic [CNT_W-1:0] THR_HI_V = CNT_W'(THR_HI);

  logic             brk_en, thr_hi, cont_mode, hold_mode;
  logic             start, stop, braking, finished, drive_held;
  logic [CNT_W-1:0] frame_total, threshold;
  brake_st_e        state;

  brake_mode_regs u_modes (
    .clk, .rst_n, .cmd_valid, .cmd_code,
    .brk_en, .thr_hi, .cont_mode, .hold_mode
  );

  efm_frame_counter #(.CNT_W(CNT_W)) u_count (
    .clk, .rst_n, .efm_in, .frame_strobe, .frame_total
  );

  assign start     = cmd_valid && cmd_code == CMD_BRAKE && brk_en;
  assign stop      = cmd_valid && cmd_code == CMD_STOP;
  assign threshold = thr_hi ? THR_HI_V : THR_LO_V;

  brake_seq #(.CNT_W(CNT_W)) u_seq (
    .clk, .rst_n, .start, .stop, .frame_strobe,
    .frame_total, .threshold, .state
  );

  assign braking    = state == ST_BRAKE;
  assign finished   = state == ST_DONE;
  assign drive_held = braking || (finished && cont_mode);

  assign brake_done    = finished;
  assign motor_drv_out = (state == ST_IDLE) ? servo_motor_in : drive_held;
  assign track_off_out = (hold_mode && drive_held) ? 1'b0 : servo_trkoff_in;

  // R3: an accepted brake code drives the motor and clears completion
  a_r3_start_drive: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (motor_drv_out && !brake_done));
  // R5 / R8: completion drops the drive only outside continuous mode
  a_r5_done_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_done && !cont_mode) |-> !motor_drv_out);
  a_r8_cont_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_done && cont_mode) |-> motor_drv_out);
  // R9: hold mode keeps tracking off during braking
  a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && braking) |-> !track_off_out);
  // R10: stop clears completion
  a_r10_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !brake_done);
endmodule

// File: tb/disc_brake_ctrl_test.sv
module disc_brake_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_code;
  logic       efm_in;
  logic       frame_strobe;
  logic       servo_motor_in;
  logic       servo_trkoff_in;
  logic       motor_drv_out;
  logic       brake_done;
  logic       track_off_out;

  int total = 0;
  int bad   = 0;

  disc_brake_ctrl uut (
    .clk, .rst_n, .cmd_valid, .cmd_code, .efm_in, .frame_strobe,
    .servo_motor_in, .servo_trkoff_in,
    .motor_drv_out, .brake_done, .track_off_out
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] code);
    cmd_valid = 1'b1;
    cmd_code  = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 8'h00;
    @(negedge clk);
  endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) begin
      efm_in = ~efm_in;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 done low", brake_done, 1'b0);
    chk("R1 motor follows servo", motor_drv_out, servo_motor_in);
    chk("R1 trkoff follows servo", track_off_out, servo_trkoff_in);
    send(8'h06);
    chk("R1 brake disabled by default", motor_drv_out, 1'b0);
  endtask

  task automatic t_disable();
    send(8'hC5);
    send(8'hC4);
    send(8'h06);
    chk("R2 ignored brake motor", motor_drv_out, 1'b0);
    chk("R2 ignored brake done", brake_done, 1'b0);
    send(8'hC5);
    send(8'h06);
    chk("R2 R3 brake starts when enabled", motor_drv_out, 1'b1);
    send(8'h02);
  endtask

  task automatic t_basic();
    send(8'h06);
    chk("R3 motor high", motor_drv_out, 1'b1);
    chk("R3 done low", brake_done, 1'b0);
    frame(0);
    chk("R4 arming strobe no decision", brake_done, 1'b0);
    frame(10);
    chk("R4 fast frame keeps braking", brake_done, 1'b0);
    frame(4);
    chk("R5 count equal threshold", brake_done, 1'b0);
    frame(3);
    chk("R5 done high", brake_done, 1'b1);
    chk("R5 motor low", motor_drv_out, 1'b0);
    send(8'h06);
    chk("R3 new brake clears done", brake_done, 1'b0);
    frame(1);
    chk("R4 first frame after restart arms only", brake_done, 1'b0);
    send(8'h02);
    chk("R10 stop idle motor", motor_drv_out, servo_motor_in);
  endtask

  task automatic t_saturate();
    send(8'h06);
    frame(2);
    frame(18);
    chk("R7 no wrap at 18", brake_done, 1'b0);
    frame(2);
    chk("R7 then ends", brake_done, 1'b1);
    send(8'h02);
    chk("R10 stop clears done", brake_done, 1'b0);
  endtask

  task automatic t_thr8();
    send(8'hA3);
    send(8'h06);
    frame(0);
    frame(8);
    chk("R6 count 8 at thr 8", brake_done, 1'b0);
    frame(7);
    chk("R6 count 7 ends at thr 8", brake_done, 1'b1);
    send(8'h02);
    do_reset();
    send(8'hC5);
    send(8'h06);
    frame(0);
    frame(5);
    chk("R6 R1 reset restores thr 4", brake_done, 1'b0);
    send(8'h02);
  endtask

  task automatic t_cont();
    send(8'hCB);
    send(8'h06);
    frame(0);
    frame(1);
    chk("R8 done in continuous", brake_done, 1'b1);
    chk("R8 drive kept", motor_drv_out, 1'b1);
    send(8'hCA);
    chk("R8 leaving continuous drops drive", motor_drv_out, 1'b0);
    send(8'h02);
  endtask

  task automatic t_hold();
    send(8'hCD);
    send(8'h06);
    chk("R9 trkoff held low", track_off_out, 1'b0);
    send(8'hCC);
    chk("R9 hold off follows servo", track_off_out, 1'b1);
    send(8'h02);
    chk("R10 stop trkoff follows servo", track_off_out, servo_trkoff_in);
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_code = 8'h00;
    efm_in = 1'b0;
    frame_strobe = 1'b0;
    servo_motor_in = 1'b0;
    servo_trkoff_in = 1'b1;
    @(negedge clk);
    t_reset();
    t_disable();
    t_basic();
    t_saturate();
    t_thr8();
    t_cont();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule